// File: doc/BRIEF.md
# Interleaved Bank Block Fetch Controller

This controller refills one cache line from a main memory made of several word-wide banks. Consecutive words of a line sit in consecutive banks, because a word's bank is picked by the low bits of its word address. One line refill is one request. The controller forwards the line's row to every bank in a single address cycle. All banks then run their fixed access latency side by side, and the words come back over one shared word-wide bus, one word per cycle, lowest bank first.

With four banks, a six-cycle access and a one-cycle word transfer, a refill takes 1 + 6 + 4 = 11 cycles instead of the 32 cycles that four serial word fetches would need. A bank is a fixed-latency store. Its contents are loaded through a word write port that uses the same address-to-bank mapping. Only one refill is in flight at a time. The request handshake stays closed from the accepted request until the last word has been returned.

Top module: `ilv_fill_ctrl`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1 and both `rd_valid` and `rd_done` are 0.
- R2: A write with `wr_en` high stores `wr_data` at word address `wr_addr`. That word lives in bank `wr_addr[1:0]`, row `wr_addr[ADDR_W-1:2]`. A later refill of that row returns it at position `wr_addr[1:0]`.
- R3: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the refill ends. Requests raised while `req_ready` is 0 are ignored.
- R4: The low two bits of `req_addr` are ignored. A refill always returns the whole line of row `req_addr[ADDR_W-1:2]`, starting at word 0.
- R5: The first word is valid in the cycle after the seventh clock edge that follows the accepting edge. That is 1 address cycle plus 6 bank-access cycles.
- R6: The words of a line appear on four consecutive cycles. `rd_word` counts 0, 1, 2, 3, and `rd_data` carries the word held by that bank.
- R7: `rd_done` is 1 for exactly one cycle, together with the last word, and only then.
- R8: `req_ready` returns to 1 in the cycle after the `rd_done` cycle, so a refill holds the port for 1 + LAT + NB cycles.
- R9: A reset raised during a refill abandons it. No word of that line is returned afterwards, and the next request is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Refill request |
| req_addr | input | ADDR_W | Word address of the line; the low 2 bits are ignored |
| req_ready | output | 1 | Controller idle and able to take a request |
| wr_en | input | 1 | Bank word write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data |
| rd_valid | output | 1 | A returned word is on `rd_data` |
| rd_data | output | DATA_W | Returned word |
| rd_word | output | 2 | Position of the returned word in the line |
| rd_done | output | 1 | Last word of the line this cycle |

## Verification
Counting from the edge that accepts a request, `req_ready` falls after that edge. Word k appears after edge 7 + k, `rd_done` comes with word 3 after edge 10, and `req_ready` rises again after edge 11. The bench keeps a behavioural timeline of edges since acceptance, together with its own copy of the memory contents. It drives inputs and compares every output on the falling edge, half a period clear of the registers, so each expected value is matched against the cycle it is due in. Busy-time requests, unaligned addresses and a reset in mid-refill are checked against the same timeline.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  // Shortest access latency the bank read stage supports: the array
  // is read one cycle before the access ends.
  localparam int unsigned ILV_MIN_LAT = 2;

  // Width of a countdown that must hold the value lat.
  function automatic int unsigned ilv_cnt_w(input int unsigned lat);
    return $clog2(lat + 1);
  endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank
  import ilv_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ROW_W  = 6,
  parameter int unsigned LAT    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              start,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [DATA_W-1:0] q,
  output logic              busy,
  output logic              last
);

  localparam int unsigned CW    = ilv_cnt_w(LAT);
  localparam int unsigned DEPTH = 1 << ROW_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CW-1:0]     cnt;

  // Access countdown: loaded when the address arrives, runs to zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= CW'(LAT);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  // Plain array with a registered read port, so it can map to block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_row] <= wr_data;
    end
    if (cnt == CW'(2)) begin
      q <= mem[rd_row];
    end
  end

  assign busy = (cnt != '0);
  assign last = (cnt == CW'(1));

endmodule

// File: rtl/ilv_return_seq.sv
module ilv_return_seq #(
  parameter int unsigned NB     = 4,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned IW    = $clog2(NB)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [NB*DATA_W-1:0] words,
  output logic               rd_valid,
  output logic [DATA_W-1:0]  rd_data,
  output logic [IW-1:0]      rd_word,
  output logic               rd_done
);

  logic          active;
  logic [IW-1:0] idx;

  // One bank word per cycle onto the shared bus, lowest bank first.
  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      idx      <= '0;
      rd_valid <= 1'b0;
      rd_done  <= 1'b0;
      rd_word  <= '0;
      rd_data  <= '0;
    end else if (start) begin
      rd_valid <= 1'b1;
      rd_data  <= words[0 +: DATA_W];
      rd_word  <= '0;
      rd_done  <= (NB == 1);
      idx      <= IW'(1);
      active   <= (NB > 1);
    end else if (active) begin
      rd_valid <= 1'b1;
      rd_data  <= words[idx*DATA_W +: DATA_W];
      rd_word  <= idx;
      rd_done  <= (idx == IW'(NB - 1));
      active   <= (idx != IW'(NB - 1));
      idx      <= idx + 1'b1;
    end else begin
      rd_valid <= 1'b0;
      rd_done  <= 1'b0;
    end
  end

endmodule

// File: rtl/ilv_fill_ctrl.sv
module ilv_fill_ctrl #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NB     = 4,
  parameter int unsigned LAT    = 6,
  localparam int unsigned BSEL_W = $clog2(NB),
  localparam int unsigned ROW_W  = ADDR_W - BSEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [BSEL_W-1:0] rd_word,
  output logic              rd_done
);

  logic              accept;
  logic              send_q;
  logic [ROW_W-1:0]  row_q;
  logic [BSEL_W-1:0] wr_bank;
  logic [ROW_W-1:0]  wr_row;
  logic [NB-1:0]     bank_busy;
  logic [NB-1:0]     bank_last;
  logic [NB*DATA_W-1:0] bank_q;

  assign accept  = req_valid && req_ready;
  assign wr_bank = wr_addr[BSEL_W-1:0];
  assign wr_row  = wr_addr[ADDR_W-1:BSEL_W];

  // Handshake and the one-cycle address send to every bank.
  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready <= 1'b1;
      send_q    <= 1'b0;
      row_q     <= '0;
    end else begin
      send_q <= accept;
      if (accept) begin
        req_ready <= 1'b0;
        row_q     <= req_addr[ADDR_W-1:BSEL_W];
      end else if (rd_done && (bank_busy == '0)) begin
        req_ready <= 1'b1;
      end
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    ilv_bank #(
      .DATA_W(DATA_W),
      .ROW_W (ROW_W),
      .LAT   (LAT)
    ) u_bank (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (wr_en && (wr_bank == BSEL_W'(b))),
      .wr_row (wr_row),
      .wr_data(wr_data),
      .start  (send_q),
      .rd_row (row_q),
      .q      (bank_q[b*DATA_W +: DATA_W]),
      .busy   (bank_busy[b]),
      .last   (bank_last[b])
    );
  end

  ilv_return_seq #(
    .NB    (NB),
    .DATA_W(DATA_W)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (&bank_last),
    .words   (bank_q),
    .rd_valid(rd_valid),
    .rd_data (rd_data),
    .rd_word (rd_word),
    .rd_done (rd_done)
  );

endmodule

// File: rtl/ilv_fill_ctrl_chk.sv
module ilv_fill_ctrl_chk #(
  parameter int unsigned BSEL_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [BSEL_W-1:0] rd_word,
  input logic              rd_done
);

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_ready && !rd_valid && !rd_done));

  // R3
  accept_closes_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R3
  no_ready_in_return_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !req_ready);

  // R6
  first_word_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_valid) |-> (rd_word == '0));

  // R6
  words_in_order_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_done) |=> (rd_valid && (rd_word == BSEL_W'($past(rd_word) + 1'b1))));

  // R7
  done_with_word_chk: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> (rd_valid && (rd_word == '1)));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> !rd_done);

  // R8
  ready_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> req_ready);

endmodule

bind ilv_fill_ctrl ilv_fill_ctrl_chk #(.BSEL_W(BSEL_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rd_valid (rd_valid),
  .rd_word  (rd_word),
  .rd_done  (rd_done)
);

// File: tb/ilv_fill_ctrl_bench.sv
`timescale 1ns/1ps
module ilv_fill_ctrl_bench;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int NB     = 4;
  localparam int LAT    = 6;
  localparam int BSEL_W = 2;

  logic              clk = 1'b0;
  logic              rst;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic              req_ready;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              rd_valid;
  logic [DATA_W-1:0] rd_data;
  logic [BSEL_W-1:0] rd_word;
  logic              rd_done;

  ilv_fill_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NB(NB), .LAT(LAT)
  ) u_ilv_fill_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_word(rd_word), .rd_done(rd_done)
  );

  always #2 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  int n_seen_valid = 0;
  bit cmp_on = 1'b0;

  // Behavioural model: memory image and edges elapsed since acceptance.
  logic [DATA_W-1:0] m_mem [2**ADDR_W];
  int m_t = -1;
  int m_row = 0;

  always @(posedge clk) begin
    if (wr_en) m_mem[wr_addr] = wr_data;
    if (rst) begin
      m_t = -1;
    end else if (m_t >= 0) begin
      m_t++;
      if (m_t > LAT + NB) m_t = -1;
    end else if (req_valid) begin
      m_t   = 0;
      m_row = int'(req_addr) / NB;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison on the falling edge.
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      automatic bit e_valid = (m_t >= LAT + 1) && (m_t <= LAT + NB);
      automatic int e_word  = m_t - LAT - 1;
      if (rd_valid) n_seen_valid++;
      chk((m_t < 0) ? "R8 ready" : "R3 ready", int'(req_ready), int'(m_t < 0));
      chk("R5 valid", int'(rd_valid), int'(e_valid));
      chk("R7 done", int'(rd_done), int'(m_t == LAT + NB));
      if (e_valid) begin
        chk("R6 word", int'(rd_word), e_word);
        chk("R2,R6 data", int'(rd_data), int'(m_mem[m_row * NB + e_word]));
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fill(input logic [ADDR_W-1:0] a);
    req_valid = 1'b1;
    req_addr  = a;
    step(1);
    req_valid = 1'b0;
    step(LAT + NB + 3);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_addr = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    step(3);
    rst = 1'b0;
    // R1: idle outputs straight after reset
    chk("R1 ready", int'(req_ready), 1);
    chk("R1 valid", int'(rd_valid), 0);
    chk("R1 done", int'(rd_done), 0);
    cmp_on = 1'b1;

    // R2: load 16 lines through the bank write port
    for (int a = 0; a < 64; a++) begin
      wr_en = 1'b1; wr_addr = ADDR_W'(a);
      wr_data = DATA_W'(a * 16'h0101) ^ 16'h5a3c;
      step(1);
    end
    wr_en = 1'b0;

    fill(8'h00);                       // R5 R6 R7 aligned line
    fill(8'h0d);                       // R4 low bits 01 ignored, row 3
    fill(8'h3b);                       // R4 low bits 11 ignored, row 14

    // R3: request held high, refills run back to back
    req_valid = 1'b1; req_addr = 8'h14;
    step(30);
    req_valid = 1'b0;
    step(LAT + NB + 3);

    // R3: request pulses while busy are ignored
    req_valid = 1'b1; req_addr = 8'h08;
    step(1);
    req_valid = 1'b0;
    step(3);
    req_valid = 1'b1; req_addr = 8'h1c;
    step(2);
    req_valid = 1'b0;
    step(LAT + NB + 3);

    // R2: overwrite word 9 (bank 1, row 2) and refill that row
    wr_en = 1'b1; wr_addr = 8'h09; wr_data = 16'hbeef;
    step(1);
    wr_en = 1'b0;
    fill(8'h08);

    // R9: reset in mid-refill leaves no word behind
    req_valid = 1'b1; req_addr = 8'h18;
    step(1);
    req_valid = 1'b0;
    step(3);
    n_seen_valid = 0;
    rst = 1'b1;
    step(1);
    rst = 1'b0;
    step(LAT + NB + 4);
    chk("R9 stray words", n_seen_valid, 0);
    fill(8'h1c);                       // R9 recovery refill

    finish_run();
  end

endmodule